// File: doc/BRIEF.md
# I2C Master Byte FIFO Control and Status Unit

This unit sits between a processor-side register port and the byte engine of an I2C master. It holds two 16-byte queues: one carries bytes toward the engine and the other carries bytes coming back from it. Software loads outgoing bytes and drains incoming bytes through a single data register. It sets the fill levels that raise status flags and reads the occupancy of each queue. It can also empty either queue with a control write.

The engine side has two valid/ready streams. On the outgoing stream, `tx_valid` is high whenever the transmit queue holds a byte. The head byte is held stable on `tx_data` and is removed on the edge where `tx_ready` is high; the engine may hold `tx_ready` low for as long as it likes. On the incoming stream, `rx_ready` is low while the receive queue is full. A byte on `rx_data` is taken only on an edge where both `rx_valid` and `rx_ready` are high. The engine must keep `rx_valid` and `rx_data` unchanged until that edge. The engine pulses `eng_last_done` when it has finished shifting out a byte.

Three sticky status flags report the fill levels and the end of a transfer. Software clears a flag by writing 0 to it. A single interrupt line combines the flags with an enable mask.

Top module: `i2c_fifo_ctrl`

Register map (address on `reg_addr`): 0 control, 1 status, 2 interrupt enable, 3 data port, 4 receive count, 5 transmit count. `reg_rdata` is combinational and follows `reg_addr` whenever `reg_rd` is high. A read or write takes effect on the clock edge where the strobe is high.

## Requirements
- R1: Each queue holds up to 16 bytes. Address 4 returns the receive count and address 5 returns the transmit count. Both counts are 0 after reset, and the status, enable and control registers also read 0 out of reset.
- R2: A write to address 3 pushes `reg_wdata` into the transmit queue. When the queue already holds 16 bytes, the write is dropped and the count stays at 16.
- R3: A read of address 3 returns the oldest received byte and removes it. A read while the receive queue is empty returns 0 and leaves the count at 0.
- R4: A control write (address 0) with bit 0 set empties the transmit queue, and one with bit 1 set empties the receive queue. Each reset bit leaves the other queue untouched.
- R5: Control bits [7:4] hold the receive trigger T. Status bit 1 sets once the receive count is at least T+1.
- R6: Control bits [3:2] hold the transmit code. The bytes-left level is 8 for code 0, 4 for code 1, 2 for code 2 and 0 for code 3. Status bit 0 sets once the transmit count is at or below that level.
- R7: Status bit 2 sets when `eng_last_done` pulses while the transmit queue is empty. A pulse while bytes remain does not set it.
- R8: Writing a 0 to a status bit clears it and writing a 1 leaves it unchanged. A flag whose condition still holds sets again on the next cycle, and a flag whose condition has ended stays set until it is cleared.
- R9: `irq` is high exactly when some status bit and the enable bit at the same position (address 2) are both 1.
- R10: `tx_valid` is high exactly when the transmit queue is non-empty, and bytes leave in the order they were written. `rx_ready` is low exactly when the receive queue holds 16 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while reg_rd is high |
| irq | output | 1 | Combined interrupt request |
| tx_valid | output | 1 | Outgoing byte available |
| tx_ready | input | 1 | Engine takes the outgoing byte |
| tx_data | output | 8 | Head of the transmit queue |
| rx_valid | input | 1 | Engine offers an incoming byte |
| rx_ready | output | 1 | Receive queue can accept a byte |
| rx_data | input | 8 | Incoming byte |
| eng_last_done | input | 1 | Pulse: engine finished shifting a byte |

## Verification
Some properties are checked on every cycle:
- neither queue count ever exceeds its depth, a push into a full queue or a pop from an empty queue leaves the count unchanged, and a reset bit empties its queue on the next cycle (R1-type bounds, R2, R3, R4);
- a set receive flag stays set until a 0 is written to it (R8);
- the transfer-end flag rises only after an engine pulse that arrived while the transmit queue was empty (R7).

Other behaviour can only be shown by the directed scenarios:
- byte ordering through both queues (R10);
- the exact trigger points for each transmit code and receive field value (R5, R6);
- the value read from an empty data port (R3);
- the enable mask combining into `irq` (R9).

// File: rtl/i2c_fifo_pkg.sv
package i2c_fifo_pkg;

  typedef enum logic [2:0] {
    ADR_CTRL  = 3'd0,
    ADR_STAT  = 3'd1,
    ADR_IEN   = 3'd2,
    ADR_DATA  = 3'd3,
    ADR_RXCNT = 3'd4,
    ADR_TXCNT = 3'd5
  } reg_addr_e;

  localparam int FLG_TXLOW = 0;
  localparam int FLG_RXHIT = 1;
  localparam int FLG_TEND  = 2;
  localparam int NFLAG     = 3;

  // bytes-left level selected by the two-bit transmit code
  function automatic int unsigned tx_level(input logic [1:0] code, input int unsigned depth);
    case (code)
      2'd0:    return depth / 2;
      2'd1:    return depth / 4;
      2'd2:    return 2;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/byte_queue.sv
module byte_queue #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign dout    = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> (count == CW'(DEPTH)));
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !clr) |=> (count == '0));
  a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

endmodule

// File: rtl/fifo_flags.sv
module fifo_flags
  import i2c_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    tx_count,
  input  logic [CW-1:0]    rx_count,
  input  logic [1:0]       tx_code,
  input  logic [TW-1:0]    rx_trig,
  input  logic             eng_done,
  input  logic             stat_wr,
  input  logic [NFLAG-1:0] stat_wdata,
  input  logic [NFLAG-1:0] ien,
  output logic [NFLAG-1:0] stat,
  output logic             irq
);

  logic [NFLAG-1:0] cond;
  logic [CW-1:0]    tx_lvl;
  logic [CW-1:0]    rx_hit;

  assign tx_lvl = CW'(tx_level(tx_code, DEPTH));
  assign rx_hit = CW'(rx_trig) + CW'(1);

  always_comb begin
    cond            = '0;
    cond[FLG_TXLOW] = (tx_count <= tx_lvl);
    cond[FLG_RXHIT] = (rx_count >= rx_hit);
    cond[FLG_TEND]  = eng_done && (tx_count == '0);
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    logic clr_i;
    assign clr_i = stat_wr && !stat_wdata[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat[i] <= 1'b0;
      else        stat[i] <= cond[i] || (stat[i] && !clr_i);
    end
  end

  assign irq = |(stat & ien);

  a_r8_sticky_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[FLG_RXHIT] && !(stat_wr && !stat_wdata[FLG_RXHIT])) |=> stat[FLG_RXHIT]);
  a_r7_tend_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[FLG_TEND]) |-> $past(eng_done && (tx_count == '0)));
  a_r5_rx_reach: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count >= rx_hit) |=> stat[FLG_RXHIT]);

endmodule

// File: rtl/i2c_fifo_ctrl.sv
module i2c_fifo_ctrl
  import i2c_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int DW   = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [DW-1:0] rx_data,
  input  logic          eng_last_done
);

  logic [TW-1:0]    rx_trig_q;
  logic [1:0]       tx_code_q;
  logic [NFLAG-1:0] ien_q;
  logic [NFLAG-1:0] stat;

  logic          wr_ctrl, wr_data, rd_data;
  logic [CW-1:0] tx_count, rx_count;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [DW-1:0] rx_head;

  assign wr_ctrl = reg_wr && (reg_addr == ADR_CTRL);
  assign wr_data = reg_wr && (reg_addr == ADR_DATA);
  assign rd_data = reg_rd && (reg_addr == ADR_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_trig_q <= '0;
      tx_code_q <= '0;
      ien_q     <= '0;
    end else begin
      if (wr_ctrl) begin
        rx_trig_q <= reg_wdata[4 +: TW];
        tx_code_q <= reg_wdata[3:2];
      end
      if (reg_wr && (reg_addr == ADR_IEN)) ien_q <= reg_wdata[NFLAG-1:0];
    end
  end

  byte_queue #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (wr_ctrl && reg_wdata[0]),
    .push  (wr_data),
    .din   (reg_wdata),
    .pop   (tx_ready),
    .dout  (tx_data),
    .count (tx_count),
    .full  (tx_full),
    .empty (tx_empty)
  );

  byte_queue #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (wr_ctrl && reg_wdata[1]),
    .push  (rx_valid),
    .din   (rx_data),
    .pop   (rd_data),
    .dout  (rx_head),
    .count (rx_count),
    .full  (rx_full),
    .empty (rx_empty)
  );

  assign tx_valid = !tx_empty;
  assign rx_ready = !rx_full;

  fifo_flags #(.DEPTH(DEPTH)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_count   (tx_count),
    .rx_count   (rx_count),
    .tx_code    (tx_code_q),
    .rx_trig    (rx_trig_q),
    .eng_done   (eng_last_done),
    .stat_wr    (reg_wr && (reg_addr == ADR_STAT)),
    .stat_wdata (reg_wdata[NFLAG-1:0]),
    .ien        (ien_q),
    .stat       (stat),
    .irq        (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        ADR_CTRL:  reg_rdata = {rx_trig_q, tx_code_q, 2'b00};
        ADR_STAT:  reg_rdata = 8'(stat);
        ADR_IEN:   reg_rdata = 8'(ien_q);
        ADR_DATA:  reg_rdata = rx_empty ? '0 : rx_head;
        ADR_RXCNT: reg_rdata = 8'(rx_count);
        ADR_TXCNT: reg_rdata = 8'(tx_count);
        default:   reg_rdata = '0;
      endcase
    end
  end

  a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !wr_ctrl) |=> (tx_valid && $stable(tx_data)));
  a_r2_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && wr_data && !tx_ready && !wr_ctrl) |=> tx_full);

endmodule

// File: tb/i2c_fifo_ctrl_tb.sv
module i2c_fifo_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq, tx_valid, rx_ready;
  logic       tx_ready = 1'b0, rx_valid = 1'b0, eng_last_done = 1'b0;
  logic [7:0] tx_data;
  logic [7:0] rx_data = '0;

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  i2c_fifo_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .eng_last_done(eng_last_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #2 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic eng_push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic eng_pop(output logic [7:0] b);
    @(negedge clk);
    tx_ready = 1'b1;
    #2 b = tx_data;
    @(posedge clk); #1;
    tx_ready = 1'b0;
  endtask

  task automatic eng_done_pulse();
    @(negedge clk);
    eng_last_done = 1'b1;
    @(posedge clk); #1;
    eng_last_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(3'd5, d); chk("R1 tx count after reset", d, 0);
    rd(3'd4, d); chk("R1 rx count after reset", d, 0);
    rd(3'd0, d); chk("R1 ctrl after reset", d, 0);
    rd(3'd2, d); chk("R1 ien after reset", d, 0);
    idle(2);
    rd(3'd1, d); chk("R6 tx low flag with empty queue, code 0", d, 8'h01);
    chk("R9 irq with enables off", irq, 0);
    chk("R10 tx_valid when empty", tx_valid, 0);
    chk("R10 rx_ready when empty", rx_ready, 1);
  endtask

  task automatic t_tx_fill();
    logic [7:0] d;
    for (int i = 0; i < 17; i++) wr(3'd3, 8'hA0 + 8'(i));
    rd(3'd5, d); chk("R2 tx count capped at 16", d, 16);
    chk("R10 tx_valid when non-empty", tx_valid, 1);
    for (int i = 0; i < 16; i++) begin
      eng_pop(d);
      chk("R10 tx byte order", d, 8'hA0 + i);
    end
    rd(3'd5, d); chk("R2 dropped 17th byte, tx count 0", d, 0);
    chk("R10 tx_valid after drain", tx_valid, 0);
  endtask

  task automatic t_rx();
    logic [7:0] d;
    eng_push(8'h11); eng_push(8'h22); eng_push(8'h33);
    rd(3'd4, d); chk("R1 rx count 3", d, 3);
    rd(3'd3, d); chk("R3 rx first byte", d, 8'h11);
    rd(3'd3, d); chk("R3 rx second byte", d, 8'h22);
    rd(3'd3, d); chk("R3 rx third byte", d, 8'h33);
    rd(3'd3, d); chk("R3 empty read returns 0", d, 0);
    rd(3'd4, d); chk("R3 empty read keeps count 0", d, 0);
    for (int i = 0; i < 16; i++) eng_push(8'(i));
    chk("R10 rx_ready low when full", rx_ready, 0);
    wr(3'd0, 8'h02);
    rd(3'd4, d); chk("R4 rx reset empties rx queue", d, 0);
    chk("R10 rx_ready after reset", rx_ready, 1);
  endtask

  task automatic t_rx_trig();
    logic [7:0] d;
    wr(3'd0, 8'h30);
    wr(3'd1, 8'h00);
    eng_push(8'h01); eng_push(8'h02); eng_push(8'h03);
    idle(2);
    rd(3'd1, d); chk("R5 rx flag clear below trigger+1", d & 8'h02, 0);
    eng_push(8'h04);
    idle(2);
    rd(3'd1, d); chk("R5 rx flag set at trigger+1", d & 8'h02, 8'h02);
    for (int i = 0; i < 4; i++) rd(3'd3, d);
    idle(2);
    rd(3'd1, d); chk("R8 rx flag stays set after condition ends", d & 8'h02, 8'h02);
    wr(3'd1, 8'h05);
    idle(1);
    rd(3'd1, d); chk("R8 write 0 clears rx flag", d & 8'h02, 0);
  endtask

  task automatic t_tx_trig();
    logic [7:0] d;
    wr(3'd0, 8'h08);
    for (int i = 0; i < 5; i++) wr(3'd3, 8'(i));
    wr(3'd1, 8'h00);
    idle(1);
    rd(3'd1, d); chk("R6 code 2 flag clear at 5 left", d & 8'h01, 0);
    for (int i = 0; i < 2; i++) eng_pop(d);
    idle(2);
    rd(3'd1, d); chk("R6 code 2 flag clear at 3 left", d & 8'h01, 0);
    eng_pop(d);
    idle(2);
    rd(3'd1, d); chk("R6 code 2 flag set at 2 left", d & 8'h01, 8'h01);
    wr(3'd0, 8'h0C);
    wr(3'd1, 8'h00);
    idle(1);
    rd(3'd1, d); chk("R6 code 3 flag clear at 2 left", d & 8'h01, 0);
    eng_pop(d); eng_pop(d);
    idle(2);
    rd(3'd1, d); chk("R6 code 3 flag set at empty", d & 8'h01, 8'h01);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_reset_bits();
    logic [7:0] d;
    for (int i = 0; i < 3; i++) wr(3'd3, 8'(i));
    eng_push(8'h55); eng_push(8'h66);
    wr(3'd0, 8'h01);
    rd(3'd5, d); chk("R4 tx reset empties tx queue", d, 0);
    rd(3'd4, d); chk("R4 tx reset leaves rx queue", d, 2);
    wr(3'd3, 8'h77);
    wr(3'd0, 8'h02);
    rd(3'd4, d); chk("R4 rx reset empties rx queue", d, 0);
    rd(3'd5, d); chk("R4 rx reset leaves tx queue", d, 1);
    wr(3'd0, 8'h01);
  endtask

  task automatic t_tend();
    logic [7:0] d;
    wr(3'd3, 8'h9A);
    wr(3'd1, 8'h00);
    eng_done_pulse();
    idle(1);
    rd(3'd1, d); chk("R7 no tend while bytes remain", d & 8'h04, 0);
    eng_pop(d);
    eng_done_pulse();
    idle(1);
    rd(3'd1, d); chk("R7 tend set on last byte with empty queue", d & 8'h04, 8'h04);
    wr(3'd1, 8'h07);
    rd(3'd1, d); chk("R8 write 1 keeps tend", d & 8'h04, 8'h04);
    wr(3'd1, 8'h03);
    rd(3'd1, d); chk("R8 write 0 clears tend", d & 8'h04, 0);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    eng_done_pulse();
    wr(3'd2, 8'h04);
    idle(1);
    rd(3'd2, d); chk("R9 ien readback", d, 8'h04);
    chk("R9 irq from tend with its enable", irq, 1);
    wr(3'd1, 8'h03);
    idle(1);
    chk("R9 irq drops when tend cleared", irq, 0);
    wr(3'd2, 8'h00);
    idle(1);
    chk("R9 irq low with enables off", irq, 0);
    wr(3'd2, 8'h01);
    idle(1);
    chk("R9 irq from tx low flag", irq, 1);
    wr(3'd2, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    #1 rst_n = 1'b1;
    t_reset();
    t_tx_fill();
    t_rx();
    t_rx_trig();
    t_tx_trig();
    t_reset_bits();
    t_tend();
    t_irq();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule